// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one burst request into the stream of column addresses that the memory sees during the burst. A start strobe captures a 9-bit starting column and a 4-bit mode word. From the next cycle on, the block presents one column address per clock with a valid flag. It raises a last flag on the final beat of a fixed-length burst.

The mode word sets the burst length and the ordering. A fixed-length burst stays inside an aligned block of columns whose size equals the burst length, and wraps inside it. The ordering inside the block is sequential (the offset counts up) or interleaved (the offset is XORed with the beat number). A full-page setting walks the whole 512-column page in sequence, wrapping at the page end, until a terminate strobe stops it. The terminate strobe also cuts short any fixed-length burst.

Top module: `sdram_burst_col_gen`

## Requirements
- R1: After reset, colValid and colLast are low until a burst is started.
- R2: A startStb seen at a clock edge while idle, with termStb low, makes colValid high from the following cycle, and the first address equals the captured startCol.
- R3: burstMode[2:0] = 000, 001, 010, 011 gives bursts of 1, 2, 4, 8 beats. colLast is high only on the final beat, and colValid is low in the cycle after it.
- R4: With burstMode[3] = 0 (sequential), beat i of a length-L burst has address bits above log2(L) equal to those of startCol, and low bits equal to (startCol mod L + i) mod L.
- R5: With burstMode[3] = 1 (interleaved), beat i of a fixed-length burst has low bits equal to (startCol mod L) XOR i, and the upper bits unchanged.
- R6: burstMode[2:0] = 111 selects full page. Beat i is (startCol + i) mod 512, whatever the value of burstMode[3]. colLast never rises, and the burst runs until terminated.
- R7: The reserved codes burstMode[2:0] = 100, 101, 110 give a single-beat burst at startCol with colLast high.
- R8: termStb high at an edge while a burst is active makes colValid and colLast low in the next cycle.
- R9: startStb while a burst is active is ignored: the address sequence of the running burst continues unchanged.
- R10: termStb high at an edge while idle has no effect. If it coincides with startStb, no burst starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| startStb | input | 1 | Begin a burst (honoured when idle) |
| termStb | input | 1 | End the current burst |
| startCol | input | 9 | Starting column of the burst |
| burstMode | input | 4 | [2:0] length code, [3] ordering (1 = interleaved) |
| colAddr | output | 9 | Column address of the current beat |
| colValid | output | 1 | colAddr holds a burst beat |
| colLast | output | 1 | Final beat of a fixed-length burst |

## Verification
Every result follows a strobe by exactly one clock edge. Beat 0 appears in the cycle after the edge that samples startStb. Beat i appears i cycles later. The valid flag drops in the cycle after the last beat or after the edge that samples termStb. The bench drives inputs on the falling edge and compares colValid, colLast and colAddr on each following falling edge. So every beat is checked in exactly the cycle it is due, against addresses the bench computes from the start column, the mode and the beat index.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  // Strobes from the sequencer to the address datapath
  typedef struct packed {
    logic load;  // capture start column and mode, clear beat count
    logic step;  // advance to the next beat
  } pathCtrl_t;

  localparam logic [2:0] LEN_FULL = 3'b111;
endpackage

// File: rtl/burstColCtrl.sv
module burstColCtrl
  import burst_col_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startStb,
  input  logic      termStb,
  input  logic      lastBeat,
  output pathCtrl_t ctl,
  output logic      active
);
  always_comb begin
    ctl = '0;
    if (!active) ctl.load = startStb && !termStb;
    else if (!termStb && !lastBeat) ctl.step = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) active <= 1'b0;
    else if (!active) active <= ctl.load;
    else if (termStb || lastBeat) active <= 1'b0;
  end

  // R9: no capture while a burst runs
  a_r9_no_reload: assert property (@(posedge clk) disable iff (!rstN)
    (active && startStb) |-> !ctl.load);
endmodule

// File: rtl/burstColPath.sv
module burstColPath
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  pathCtrl_t        ctl,
  input  logic [COL_W-1:0] colIn,
  input  logic [3:0]       modeIn,
  output logic [COL_W-1:0] colAddr,
  output logic             lastBeat
);
  logic [COL_W-1:0] baseCol, beat, blkMask, offset, walked;
  logic [2:0]       lenCode;
  logic             interl, fullPg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseCol <= '0;
      lenCode <= '0;
      interl  <= 1'b0;
      beat    <= '0;
    end else if (ctl.load) begin
      baseCol <= colIn;
      lenCode <= modeIn[2:0];
      interl  <= modeIn[3];
      beat    <= '0;
    end else if (ctl.step) begin
      beat    <= beat + 1'b1;
    end
  end

  always_comb begin
    case (lenCode)
      3'b001:   blkMask = COL_W'(1);
      3'b010:   blkMask = COL_W'(3);
      3'b011:   blkMask = COL_W'(7);
      LEN_FULL: blkMask = '1;
      default:  blkMask = '0;
    endcase
  end

  assign fullPg = (lenCode == LEN_FULL);
  assign offset = baseCol & blkMask;

  // Ordering variant: interleave is per-bit XOR, sequential is an add
  always_comb begin
    if (interl && !fullPg) walked = offset ^ beat;
    else                   walked = offset + beat;
  end

  assign colAddr  = (baseCol & ~blkMask) | (walked & blkMask);
  assign lastBeat = !fullPg && (beat == blkMask);

  // R4: the block above the wrap bits never moves within a burst
  a_r4_block_fixed: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |=> ((colAddr & ~blkMask) == $past(colAddr & ~blkMask)));
  // R9: captured start column holds while stepping
  a_r9_base_stable: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |=> $stable(baseCol));
endmodule

// File: rtl/sdram_burst_col_gen.sv
module sdram_burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startStb,
  input  logic             termStb,
  input  logic [COL_W-1:0] startCol,
  input  logic [3:0]       burstMode,
  output logic [COL_W-1:0] colAddr,
  output logic             colValid,
  output logic             colLast
);
  pathCtrl_t ctl;
  logic      active, lastBeat;

  burstColCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .startStb(startStb), .termStb(termStb),
    .lastBeat(lastBeat), .ctl(ctl), .active(active)
  );

  burstColPath #(.COL_W(COL_W)) u_path (
    .clk(clk), .rstN(rstN), .ctl(ctl), .colIn(startCol), .modeIn(burstMode),
    .colAddr(colAddr), .lastBeat(lastBeat)
  );

  assign colValid = active;
  assign colLast  = active && lastBeat;

  a_r1_last_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    colLast |-> colValid);
  a_r2_first_beat: assert property (@(posedge clk) disable iff (!rstN)
    (!colValid && startStb && !termStb) |=> (colValid && colAddr == $past(startCol)));
  a_r3_last_ends: assert property (@(posedge clk) disable iff (!rstN)
    colLast |=> !colValid);
  a_r8_term_ends: assert property (@(posedge clk) disable iff (!rstN)
    (colValid && termStb) |=> !colValid);
  a_r10_term_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!colValid && termStb) |=> !colValid);
endmodule

// File: tb/sdram_burst_col_gen_tb.sv
`timescale 1ns/1ps
module sdram_burst_col_gen_tb;
  logic       clk = 1'b0;
  logic       rstN, startStb, termStb;
  logic [8:0] startCol, colAddr;
  logic [3:0] burstMode;
  logic       colValid, colLast;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sdram_burst_col_gen u_dut (
    .clk(clk), .rstN(rstN), .startStb(startStb), .termStb(termStb),
    .startCol(startCol), .burstMode(burstMode),
    .colAddr(colAddr), .colValid(colValid), .colLast(colLast)
  );

  // length in beats, 0 = full page
  function automatic int lenOf(input logic [3:0] md);
    case (md[2:0])
      3'b001: return 2;
      3'b010: return 4;
      3'b011: return 8;
      3'b111: return 0;
      default: return 1;
    endcase
  endfunction

  function automatic logic [8:0] expAddr(input logic [8:0] col, input logic [3:0] md, input int i);
    int L = lenOf(md);
    logic [8:0] m = (L == 0) ? 9'h1ff : 9'(L - 1);
    logic [8:0] b = 9'(i);
    logic [8:0] v = (L != 0 && md[3]) ? ((col & m) ^ b) : ((col & m) + b);
    return (col & ~m) | (v & m);
  endfunction

  task automatic check(input string req, input logic v, input logic l, input logic [8:0] a);
    nChecks++;
    if (colValid !== v || colLast !== l || (v && colAddr !== a)) begin
      nFails++;
      $display("FAIL %s: got valid=%0b last=%0b addr=%0h, expected valid=%0b last=%0b addr=%0h",
               req, colValid, colLast, colAddr, v, l, a);
    end
  endtask

  // Runs one burst. termAt < 0: none; otherwise terminate after that beat.
  // busyAt >= 0: pulse a different start on that beat (must be ignored).
  task automatic burst(input logic [8:0] col, input logic [3:0] md,
                       input int termAt, input int busyAt, input string req);
    int L = lenOf(md);
    int n;
    startCol = col; burstMode = md; startStb = 1'b1;
    @(negedge clk);
    startStb = 1'b0; startCol = ~col; burstMode = ~md;
    n = (L == 0) ? termAt + 1 : ((termAt >= 0 && termAt < L) ? termAt + 1 : L);
    for (int i = 0; i < n; i++) begin
      check(req, 1'b1, (L != 0) && (i == L - 1), expAddr(col, md, i));
      termStb  = (i == termAt);
      startStb = (i == busyAt);
      @(negedge clk);
      termStb = 1'b0; startStb = 1'b0;
    end
    check({req, " end"}, 1'b0, 1'b0, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rstN = 1'b0; startStb = 1'b0; termStb = 1'b0; startCol = '0; burstMode = '0;
    repeat (3) @(negedge clk);
    check("R1 reset", 1'b0, 1'b0, '0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle", 1'b0, 1'b0, '0);

    // directed corners
    burst(9'h005, 4'b0000, -1, -1, "R2 R3 len1");
    burst(9'h005, 4'b0001, -1, -1, "R3 R4 seq2");
    burst(9'h00e, 4'b0010, -1, -1, "R4 seq4 wrap");
    burst(9'h1fd, 4'b0011, -1, -1, "R4 seq8 wrap");
    burst(9'h0a6, 4'b1010, -1, -1, "R5 il4");
    burst(9'h133, 4'b1011, -1, -1, "R5 il8");
    burst(9'h1fe, 4'b0111, 5, -1, "R6 full wrap");
    burst(9'h010, 4'b1111, 3, -1, "R6 full type ignored");
    burst(9'h0c3, 4'b0100, -1, -1, "R7 rsv100");
    burst(9'h0c4, 4'b1101, -1, -1, "R7 rsv101");
    burst(9'h0c5, 4'b0110, -1, -1, "R7 rsv110");
    burst(9'h040, 4'b0011, 2, -1, "R8 term early");
    burst(9'h047, 4'b1011, 1, 0, "R9 busy start");
    burst(9'h100, 4'b0111, 20, 10, "R9 busy full");

    // R10: terminate while idle, and with a coincident start
    termStb = 1'b1;
    @(negedge clk);
    check("R10 term idle", 1'b0, 1'b0, '0);
    startStb = 1'b1; startCol = 9'h055; burstMode = 4'b0011;
    @(negedge clk);
    startStb = 1'b0; termStb = 1'b0;
    check("R10 start+term", 1'b0, 1'b0, '0);

    // random bursts
    for (int k = 0; k < 300; k++) begin
      logic [8:0] c = 9'($urandom);
      logic [3:0] m = 4'($urandom);
      int t = (lenOf(m) == 0) ? int'($urandom_range(0, 600)) :
              (($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 7)) : -1);
      int b = ($urandom_range(0, 2) == 0) ? int'($urandom_range(0, 3)) : -1;
      burst(c, m, t, b, "R4 R5 R6 rand");
      repeat ($urandom_range(0, 2)) begin
        @(negedge clk);
        check("R3 gap idle", 1'b0, 1'b0, '0);
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule